// File: doc/BRIEF.md
# Pedestal subtraction and requantizer

This block sits in a detector readout channel path. For each incoming sample it looks up a baseline value for that sample's channel, subtracts it, and reduces the signed difference to a narrow output word. The baseline values are kept in a memory with one entry per channel, and a host loads that memory through a simple write port. By default the sample is 10 bits unsigned, the channel index is 8 bits (256 entries), the difference is 11 bits signed, and the result is 8 bits.

Four reduction modes turn the 11-bit difference into 8 bits. Mode 0 clamps the difference to the signed 8-bit range. Modes 1, 2 and 3 drop one, two or three low-order bits and keep the next eight bits. When subtraction is turned off, the raw sample goes through the same reduction as if its baseline were zero. The subtraction enable and the mode are captured together with each sample, so they can change from one sample to the next. Results come out in input order, two clock edges after their sample.

Top module: `pedsub_requant`

## Requirements
- R1: While `rst_n` is low, and after its release until a sample is accepted, `res_valid` is 0. Reset is synchronous and active low.
- R2: Each cycle with `smp_valid` high produces exactly one result. That result has `res_valid` high two rising edges after the edge that captured the sample. Results keep input order, and no result appears without a sample.
- R3: With `sub_en` = 1, the difference is `smp_data` minus the baseline stored at index `smp_chan`. It is formed as an 11-bit two's-complement value.
- R4: With `sub_en` = 0, the difference is `smp_data` extended with a zero sign bit, that is, a baseline of zero.
- R5: `scale_mode` = 0 clamps the difference: values above 127 give 8'h7F, values below -128 give 8'h80, and other values give their low 8 bits.
- R6: `scale_mode` = 1 outputs bits 8..1 of the difference.
- R7: `scale_mode` = 2 outputs bits 9..2 of the difference.
- R8: `scale_mode` = 3 outputs bits 10..3 of the difference.
- R9: A host write (`ped_we` = 1) stores `ped_wdata` at `ped_addr`. Later samples on that channel use the new value, and other channels keep theirs.
- R10: When a host write and a sample on the same channel share a capture edge, that sample uses the previous baseline. The next sample on that channel uses the new one.
- R11: `sub_en` and `scale_mode` are taken from the same cycle as their sample. A change between back-to-back samples applies to the later sample only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 10 | Unsigned sample value |
| smp_chan | input | 8 | Channel index of the sample |
| sub_en | input | 1 | 1 = subtract baseline, 0 = baseline of zero |
| scale_mode | input | 2 | Reduction mode 0..3 |
| ped_we | input | 1 | Host write strobe for the baseline memory |
| ped_addr | input | 8 | Host write index |
| ped_wdata | input | 10 | Host write value |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 8 | Reduced result, two's complement |

## Verification
The bench drives both clamping directions: a large positive difference and a large negative one. A design that only truncated would wrap these around to the wrong sign. It checks the shift modes at the extremes of the signed range, where a design that took the wrong bit slice or shifted without sign would lose the sign bit. It puts a host write on the same edge as a read of the same channel, then sends a second sample right after. A design with a write-first memory, or one that registered the address late, would return the new value one sample too early. It also sends back-to-back samples with alternating mode and enable, so that a design which registers its controls apart from the sample would apply them to the wrong sample.

// File: rtl/pedsub_requant.sv
module pedsub_requant #(
  parameter int SAMPLE_W = 10,
  parameter int CHAN_W   = 8,
  parameter int OUT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [CHAN_W-1:0]   smp_chan,
  input  logic                sub_en,
  input  logic [1:0]          scale_mode,
  input  logic                ped_we,
  input  logic [CHAN_W-1:0]   ped_addr,
  input  logic [SAMPLE_W-1:0] ped_wdata,
  output logic                res_valid,
  output logic [OUT_W-1:0]    res_data
);

  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int DEPTH  = 1 << CHAN_W;
  localparam logic signed [DIFF_W-1:0] SAT_HI = DIFF_W'((1 <<< (OUT_W-1)) - 1);
  localparam logic signed [DIFF_W-1:0] SAT_LO = DIFF_W'(-(1 <<< (OUT_W-1)));

  logic [SAMPLE_W-1:0] ped_mem [DEPTH];
  logic [SAMPLE_W-1:0] ped_rd;
  logic [SAMPLE_W-1:0] smp_q;
  logic                vld_q;
  logic                en_q;
  logic [1:0]          mode_q;
  logic [SAMPLE_W-1:0] ped_eff;
  logic signed [DIFF_W-1:0] diff_s;
  logic [OUT_W-1:0]    red;

  always_ff @(posedge clk) begin
    if (ped_we) ped_mem[ped_addr] <= ped_wdata;
    ped_rd <= ped_mem[smp_chan];
  end

  always_ff @(posedge clk) begin
    smp_q  <= smp_data;
    en_q   <= sub_en;
    mode_q <= scale_mode;
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_valid;
  end

  assign ped_eff = en_q ? ped_rd : {SAMPLE_W{1'b0}};
  assign diff_s  = $signed({1'b0, smp_q}) - $signed({1'b0, ped_eff});

  always_comb begin
    case (mode_q)
      2'd0: begin
        if (diff_s > SAT_HI)      red = SAT_HI[OUT_W-1:0];
        else if (diff_s < SAT_LO) red = SAT_LO[OUT_W-1:0];
        else                      red = diff_s[OUT_W-1:0];
      end
      2'd1:    red = diff_s[OUT_W:1];
      2'd2:    red = diff_s[OUT_W+1:2];
      default: red = diff_s[OUT_W+2:3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= vld_q;
      if (vld_q) res_data <= red;
    end
  end

endmodule

// File: rtl/pedsub_requant_chk.sv
module pedsub_requant_chk #(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                sub_en,
  input logic [1:0]          scale_mode,
  input logic                res_valid,
  input logic [OUT_W-1:0]    res_data
);

  localparam int HI = (1 << (OUT_W-1)) - 1;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !res_valid); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ##1 res_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ##1 !res_valid); // R2

  AST_BYPASS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(sub_en, 2) && $past(scale_mode, 2) == 2'd0 &&
     int'($past(smp_data, 2)) > HI) |-> res_data == OUT_W'(HI)); // R5

  AST_BYPASS_SHIFT1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(sub_en, 2) && $past(scale_mode, 2) == 2'd1) |->
    res_data == OUT_W'({1'b0, $past(smp_data, 2)} >> 1)); // R6

  AST_BYPASS_SHIFT2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(sub_en, 2) && $past(scale_mode, 2) == 2'd2) |->
    res_data == OUT_W'({1'b0, $past(smp_data, 2)} >> 2)); // R7

  AST_BYPASS_SHIFT3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(sub_en, 2) && $past(scale_mode, 2) == 2'd3) |->
    res_data == OUT_W'({1'b0, $past(smp_data, 2)} >> 3)); // R8

endmodule

bind pedsub_requant pedsub_requant_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .sub_en(sub_en), .scale_mode(scale_mode), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/test_pedsub_requant.sv
`timescale 1ns/1ps
module test_pedsub_requant;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic [7:0] smp_chan = '0;
  logic       sub_en = 1'b1;
  logic [1:0] scale_mode = '0;
  logic       ped_we = 1'b0;
  logic [7:0] ped_addr = '0;
  logic [9:0] ped_wdata = '0;
  logic       res_valid;
  logic [7:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ped_m [256];
  logic [7:0] exp_q [$];
  string      req_q [$];

  always #2 clk = ~clk;

  pedsub_requant i_pedsub_requant (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .sub_en(sub_en), .scale_mode(scale_mode),
    .ped_we(ped_we), .ped_addr(ped_addr), .ped_wdata(ped_wdata),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [7:0] model(int s, int p, bit en, int m);
    int d;
    d = en ? s - p : s;
    if (m == 0) begin
      if (d > 127) d = 127;
      if (d < -128) d = -128;
      return d[7:0];
    end
    d = d >>> m;
    return d[7:0];
  endfunction

  task automatic push(int s, int c, bit en, int m, string req);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 10'(s); smp_chan = 8'(c);
    sub_en = en; scale_mode = 2'(m); ped_we = 1'b0;
    exp_q.push_back(model(s, ped_m[c], en, m));
    req_q.push_back(req);
  endtask

  task automatic push_collide(int s, int c, bit en, int m, int np, string req);
    push(s, c, en, m, req);
    ped_we = 1'b1; ped_addr = 8'(c); ped_wdata = 10'(np);
    ped_m[c] = np;
  endtask

  task automatic write_ped(int a, int v);
    @(negedge clk);
    smp_valid = 1'b0; ped_we = 1'b1; ped_addr = 8'(a); ped_wdata = 10'(v);
    ped_m[a] = v;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      smp_valid = 1'b0; ped_we = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected result %h, expected none", res_data);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (res_data !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", r, res_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R1: res_valid %b in reset, expected 0", res_valid);
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R1: res_valid %b after reset, expected 0", res_valid);
    end

    for (int i = 0; i < 256; i++) write_ped(i, (i * 37 + 11) % 1024);
    idle(1);

    push(600, 5, 1, 1, "R3");
    push(1023, 0, 1, 0, "R5 high");
    push(0, 27, 1, 0, "R5 low");
    push(20, 0, 1, 0, "R5 in range");
    push(0, 27, 1, 1, "R6");
    push(1023, 0, 1, 1, "R6");
    push(0, 27, 1, 2, "R7");
    push(1023, 0, 1, 2, "R7");
    push(0, 27, 1, 3, "R8");
    push(1023, 0, 1, 3, "R8");
    idle(2);
    for (int m = 0; m < 4; m++) push(1023, 27, 0, m, "R4");
    push(100, 27, 0, 0, "R4");
    idle(1);
    for (int i = 0; i < 16; i++) push(300 + i * 40, i * 11, i % 2, i % 4, "R11");
    idle(2);

    write_ped(40, 0);
    push(300, 40, 1, 2, "R9 new value");
    push(300, 41, 1, 2, "R9 other channel");
    idle(1);

    push_collide(500, 60, 1, 0, 1000, "R10 old value");
    push(500, 60, 1, 0, "R10 new value");
    idle(2);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) idle(1);
      else if (r == 1) write_ped(int'($urandom % 256), int'($urandom % 1024));
      else push(int'($urandom % 1024), int'($urandom % 256), ($urandom % 4) != 0,
                int'($urandom % 4), "R3 random");
    end
    idle(5);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule